// File: doc/BRIEF.md
# Per-Channel Change/Level Interrupt Generator

This block watches a small set of digital channel inputs and raises a single interrupt request when any enabled channel meets its programmed condition. Each channel can be told to trigger either on any transition of its input (rising or falling) or whenever the input sits at a chosen level. The inputs are asynchronous to the block clock and pass through a two-stage synchronizer before any detection is done.

Software configures the block through a simple word-addressed register bus with byte-lane enables. There are three configuration registers: enable, trigger type and level polarity. A fourth register holds one sticky status bit per channel, cleared by writing a one. The request output is high while any status bit is set for a channel whose enable bit is also set. Reads are combinational from the address.

Top module: `chan_irq_gen`

## Requirements
- R1: After reset the enable, type, polarity and status registers all read 0 and `irq` is low.
- R2: Enable sits at offset 0x0, type at 0x4, polarity at 0x8 and status at 0xC; bit n of each register belongs to channel n (channels 0 to 3).
- R3: Bits 31 to 4 of every register always read 0, and writes to them have no effect.
- R4: A write changes only the byte lanes whose `wr_be` bit is 1; the channel bits live in lane 0, so a write with `wr_be[0]` low leaves all channel settings unchanged.
- R5: A channel whose enable bit is 0 never sets its status bit.
- R6: With type bit 1 (change mode), any transition of the channel input sets its status bit; the bit is visible at the ports after the third rising clock edge following the input change.
- R7: With type bit 0 (level mode), the status bit is set while the synchronized input equals the channel's polarity bit (1 = high level, 0 = low level).
- R8: Writing 1 to a status bit clears it and writing 0 leaves it; in level mode, clearing while the level is still present leaves the bit set.
- R9: `irq` is high exactly when some status bit is set whose channel enable is 1; clearing the enable drops `irq` while the status bit stays readable.
- R10: Writing the type, polarity or enable registers while an input is steady does not set a change-mode status bit; edge history keeps tracking inputs regardless of configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_in | input | 4 | Asynchronous channel levels |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 4 | Byte address of the register (word aligned) |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables for the write |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted configuration bit shows up at `rd_data` on the very next read of that register and, for enable, at `irq` in the same cycle. A broken synchronizer or edge-history flop moves the moment a status bit appears away from the third edge after an input change, or creates a status set with no input change at all, which shows in the status readback within one or two cycles. A faulty clear path leaves a status bit stuck or drops a level-mode bit whose level is still present, both visible at the next read of offset 0xC.

// File: rtl/chan_irq_gen.sv
module chan_irq_gen #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] ch_in,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW/8-1:0] wr_be,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int NB = DW / 8;

  logic [NCH-1:0] en_q, typ_q, pol_q, sts_q;
  logic [NCH-1:0] s1_q, s2_q, prev_q;
  logic [DW-1:0]  lane_m;
  logic [NCH-1:0] wm, clr, hit, edge_v;

  always_comb begin
    for (int i = 0; i < DW; i++) lane_m[i] = wr_be[i/8];
  end

  assign wm     = lane_m[NCH-1:0];
  assign clr    = (wr_en && addr[3:2] == 2'd3) ? (wr_data[NCH-1:0] & wm) : '0;
  assign edge_v = s2_q ^ prev_q;
  assign hit    = en_q & ((typ_q & edge_v) | (~typ_q & ~(s2_q ^ pol_q)));
  assign irq    = |(sts_q & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; prev_q <= '0;
    end else begin
      s1_q <= ch_in; s2_q <= s1_q; prev_q <= s2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; typ_q <= '0; pol_q <= '0; sts_q <= '0;
    end else begin
      if (wr_en && addr[3:2] == 2'd0) en_q  <= (en_q  & ~wm) | (wr_data[NCH-1:0] & wm);
      if (wr_en && addr[3:2] == 2'd1) typ_q <= (typ_q & ~wm) | (wr_data[NCH-1:0] & wm);
      if (wr_en && addr[3:2] == 2'd2) pol_q <= (pol_q & ~wm) | (wr_data[NCH-1:0] & wm);
      sts_q <= (sts_q & ~clr) | hit;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr[3:2])
      2'd0: rd_data[NCH-1:0] = en_q;
      2'd1: rd_data[NCH-1:0] = typ_q;
      2'd2: rd_data[NCH-1:0] = pol_q;
      default: rd_data[NCH-1:0] = sts_q;
    endcase
  end

  // R3
  always_comb reserved_zero_chk: assert (rd_data[DW-1:NCH] == '0);

  // R5
  sts_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(en_q)) == '0));

  // R8
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts_q & ~clr) & ~sts_q) == '0));

  // R6
  cos_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & $past(en_q & typ_q & edge_v)) == $past(en_q & typ_q & edge_v)));

  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R4
  lane0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_be[0]) |=> $stable(en_q) && $stable(typ_q) && $stable(pol_q));
endmodule

// File: tb/sim_chan_irq_gen.sv
module sim_chan_irq_gen;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] ch_in = '0, addr = '0, wr_be = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit model_on = 0;
  logic [3:0] m_en, m_typ, m_pol, m_sts, h1, h2, h3;

  chan_irq_gen u0 (.clk, .rst_n, .ch_in, .wr_en, .addr, .wr_data, .wr_be, .rd_data, .irq);

  always #10 clk = ~clk;

  initial begin
    #4_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [3:0] merge(logic [3:0] old, logic [31:0] d, logic [3:0] be);
    return be[0] ? d[3:0] : old;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d; wr_be = be;
    @(negedge clk); wr_en = 0; wr_be = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model from R6/R7/R8/R9 timing
  always @(posedge clk) begin
    logic [3:0] cond, c;
    if (!rst_n) begin
      m_en = '0; m_typ = '0; m_pol = '0; m_sts = '0; h1 = '0; h2 = '0; h3 = '0;
    end else begin
      cond = (m_typ & (h2 ^ h3)) | (~m_typ & ~(h2 ^ m_pol));
      c = (wr_en && addr == 4'hC && wr_be[0]) ? wr_data[3:0] : '0;
      m_sts = (m_sts & ~c) | (m_en & cond);
      if (wr_en && addr == 4'h0) m_en  = merge(m_en,  wr_data, wr_be);
      if (wr_en && addr == 4'h4) m_typ = merge(m_typ, wr_data, wr_be);
      if (wr_en && addr == 4'h8) m_pol = merge(m_pol, wr_data, wr_be);
      h3 = h2; h2 = h1; h1 = ch_in;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3); rst_n = 1;
    // R1
    for (int a = 0; a < 16; a += 4) begin rd(a[3:0], d); chk("R1 reg", d, 0); end
    chk("R1 irq", {31'b0, irq}, 0);
    // R4 lane 0 disabled
    wr(4'h0, 32'hFFFF_FFFF, 4'b1110); rd(4'h0, d); chk("R4", d, 0);
    // R3 upper bits
    wr(4'h0, 32'hFFFF_FFFF, 4'b0001); rd(4'h0, d); chk("R3", d, 32'hF);
    // R2 offsets
    wr(4'h4, 32'hABCD_EF05, 4'hF); rd(4'h4, d); chk("R2 type", d, 32'h5);
    wr(4'h8, 32'h0000_000A, 4'hF); rd(4'h8, d); chk("R2 pol", d, 32'hA);
    rd(4'h0, d); chk("R2 en", d, 32'hF);
    // quiet config: ch0 change mode only
    wr(4'h0, 32'h0, 4'hF); wr(4'h8, 32'h0, 4'hF); wr(4'h4, 32'h1, 4'hF);
    wr(4'hC, 32'hF, 4'hF); wr(4'h0, 32'h1, 4'hF);
    idle(4); rd(4'hC, d); chk("R10 no spurious", d, 0);
    // R6 latency
    @(negedge clk); ch_in[0] = 1;
    @(negedge clk); chk("R6 edge1", {31'b0, irq}, 0);
    @(negedge clk); chk("R6 edge2", {31'b0, irq}, 0);
    @(negedge clk); chk("R6 edge3", {31'b0, irq}, 1);
    // R8 clear
    wr(4'hC, 32'h0, 4'hF); rd(4'hC, d); chk("R8 zero write", d, 1);
    wr(4'hC, 32'h1, 4'hF); rd(4'hC, d); chk("R8 clear", d, 0);
    // R10 polarity/type rewrites with steady input
    wr(4'h8, 32'hF, 4'hF); wr(4'h4, 32'h1, 4'hF); idle(4);
    rd(4'hC, d); chk("R10 cfg write", d, 0);
    // R7 level mode ch1 high
    wr(4'h4, 32'h1, 4'hF); wr(4'h8, 32'h2, 4'hF); wr(4'h0, 32'h3, 4'hF);
    idle(4); rd(4'hC, d); chk("R7 idle low", d, 0);
    @(negedge clk); ch_in[1] = 1; idle(4);
    rd(4'hC, d); chk("R7 level hit", d, 2);
    wr(4'hC, 32'h2, 4'hF); rd(4'hC, d); chk("R8 level held", d, 2);
    @(negedge clk); ch_in[1] = 0; idle(4);
    wr(4'hC, 32'h2, 4'hF); rd(4'hC, d); chk("R8 level gone", d, 0);
    // R5 disabled ch2
    wr(4'h4, 32'h5, 4'hF);
    @(negedge clk); ch_in[2] = 1; idle(5);
    rd(4'hC, d); chk("R5 disabled", d, 0);
    // R9 enable gating of irq
    @(negedge clk); ch_in[0] = 0; idle(4);
    chk("R9 irq on", {31'b0, irq}, 1);
    wr(4'h0, 32'h0, 4'hF); #1 chk("R9 irq off", {31'b0, irq}, 0);
    rd(4'hC, d); chk("R9 sts kept", d, 1);
    // random phase against model
    void'($urandom(32'd1234));
    model_on = 1; addr = 4'hC;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      wr_en = 0; addr = 4'hC;
      if ($urandom_range(0, 9) == 0) ch_in = 4'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        wr_en = 1; addr = 4'($urandom_range(0, 3) * 4);
        wr_data = $urandom; wr_be = 4'($urandom);
      end
      #1;
      if (!wr_en) chk("R6/R7 rand sts", rd_data, {28'b0, m_sts});
      chk("R9 rand irq", {31'b0, irq}, {31'b0, |(m_sts & m_en)});
    end
    @(negedge clk); wr_en = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule